// File: doc/BRIEF.md
# Host Command Register Unit over I2C

This block is a serial-bus slave that holds the control state of a voice processing path. A host microcontroller writes short command sequences over the two-wire bus. Each sequence is the slave address, then a command code, then an optional data byte. From these the block decodes the processing mode, the effect strength, four equalizer band gains, ten effect filter gains and a noise gate threshold. It presents all of them on output ports as register fields.

A read takes two transactions. First the host writes the query command together with a selector byte. Then it opens a read at the read address and receives one byte: either a status summary or the level of one band. The open-drain data pad is modelled by a pull-down enable. The bus lines are resynchronised to the system clock and filtered before any edge is decoded.

Top module: `vcmd_i2c_slave`

## Requirements
- R1: The slave answers the 7-bit address whose upper six bits are 100000 and whose last bit equals `addrSel`. So with `addrSel` low the write byte is 0x80 and the read byte is 0x81. Any other address gets no acknowledge.
- R2: After every byte it accepts, the slave holds SDA low (`sdaOe`=1) through the high phase of the ninth SCL pulse.
- R3: The slave changes its drive on SDA only while SCL is low. Read data is sent MSB first.
- R4: After reset the outputs are: bypass on, EQ mode 0, level code 01 (80%), noise threshold 0x1F, band codes 8/12/12/11 for bands 0..3, and every filter gain 12.
- R5: Command 0x01 sets bypass. Command 0x02 clears bypass and selects effect mode (`eqMode`=0). Command 0x03 clears bypass and selects EQ mode (`eqMode`=1).
- R6: Commands 0x05..0x09 load band codes (code = 12 - dB) for bands 0..3: 0x05 = 12/12/12/12, 0x06 = 9/13/13/11, 0x07 = 9/12/12/9, 0x08 = 7/12/12/12, 0x09 = 7/12/12/11.
- R7: Command 0x0A with data {band[7:5], code[4:0]} stores the code into that band. A code of 0 means +12 dB and 24 means -12 dB. A band above 3 or a code above 24 leaves every band unchanged.
- R8: Command 0x04 with data 0, 1 or 2 sets the level code (0 = 100%, 1 = 80%, 2 = 60%). Any other data value is ignored.
- R9: Command 0x0B with data {slot[7:4], gain[3:0]} sets filter slot 0..9 to a gain of 0..12. A slot above 9 or a gain above 12 is ignored. Slot s occupies `filterGain[4s+3:4s]`.
- R10: Command 0x0D loads the 8-bit noise threshold from its data byte.
- R11: After query selector 0x01 (command 0x0E), a read returns {4'b0, level[1:0], eqMode, bypass}.
- R12: After query selector 0x02..0x05, a read returns 24 minus the stored code of band 0..3. The result is 0x00 for -12 dB and 0x18 for +12 dB.
- R13: An unknown command is acknowledged and changes no output. A read that the master ends with a NACK returns the slave to idle, ready for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Selects the lowest address bit |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| bypass | output | 1 | Processing off |
| eqMode | output | 1 | 0 = effect mode, 1 = equalizer mode |
| fxLevel | output | 2 | Effect strength code |
| bandGain | output | 20 | Four 5-bit band codes, band 0 in the lowest bits |
| filterGain | output | 40 | Ten 4-bit filter gains, slot 0 in the lowest bits |
| noiseLevel | output | 8 | Noise gate threshold |

## Verification
The bench builds the block with its default parameters: ten filter slots, an 8-bit noise threshold and 5-bit band codes. With these values the bench can reach the boundary cases directly. It writes the band codes 0 and 24, the rejected codes 25 and a band index of 4, filter slot 9 against the rejected slot 10, and the gain limit of 12 against 13. Read results go through a scoreboard, which checks the inversion of band codes on readback and the packing of the status byte. The bench also drives `addrSel` high to show that the address follows the pin.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam int NBANDS    = 4;
  localparam int CODE_W    = 5;
  localparam int CODE_MAX  = 24;
  localparam int CODE_ZERO = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK
  } linkState_t;

  typedef struct packed {
    logic       cmdValid;
    logic       dataValid;
    logic [7:0] cmd;
    logic [7:0] data;
  } cmdStrobe_t;

  // Band codes packed {band3, band2, band1, band0}; code = 12 - dB.
  function automatic logic [NBANDS*CODE_W-1:0] presetWord(input logic [7:0] cmd);
    case (cmd)
      8'h06:   presetWord = {5'd11, 5'd13, 5'd13, 5'd9};
      8'h07:   presetWord = {5'd9,  5'd12, 5'd12, 5'd9};
      8'h08:   presetWord = {5'd12, 5'd12, 5'd12, 5'd7};
      8'h09:   presetWord = {5'd11, 5'd12, 5'd12, 5'd7};
      default: presetWord = {5'd12, 5'd12, 5'd12, 5'd12};
    endcase
  endfunction

  localparam logic [NBANDS*CODE_W-1:0] BAND_RST = {5'd11, 5'd12, 5'd12, 5'd8};
endpackage

// File: rtl/vcmd_link_ctrl.sv
module vcmd_link_ctrl
  import vcmd_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] txByte,
  output logic       sdaOe,
  output cmdStrobe_t strobe
);
  logic [2:0] sclSh, sdaSh;
  logic       sclF, sdaF, sclPrev, sdaPrev;
  linkState_t state;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;
  logic [7:0] shReg, cmdReg, txSh;
  logic       rwBit, ackd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1; sdaSh <= '1;
      sclF <= 1'b1; sdaF <= 1'b1; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSh <= {sclSh[1:0], sclIn};
      sdaSh <= {sdaSh[1:0], sdaIn};
      if (sclSh[2] == sclSh[1]) sclF <= sclSh[2];
      if (sdaSh[2] == sdaSh[1]) sdaF <= sdaSh[2];
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  logic sclRise, sclFall, startC, stopC;
  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startC  = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopC   = sclF & sclPrev & ~sdaPrev & sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; byteIdx <= '0;
      shReg <= '0; cmdReg <= '0; txSh <= '0;
      rwBit <= 1'b0; ackd <= 1'b0; sdaOe <= 1'b0; strobe <= '0;
    end else begin
      strobe <= '0;
      if (startC) begin
        state <= ST_RX; bitCnt <= '0; byteIdx <= '0; sdaOe <= 1'b0;
      end else if (stopC) begin
        state <= ST_IDLE; sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (byteIdx == 2'd0) begin
                if (shReg[7:1] == {ADDR_HI, addrSel}) begin
                  rwBit <= shReg[0]; sdaOe <= 1'b1; state <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaOe <= 1'b1; state <= ST_ACK;
                if (byteIdx == 2'd1) begin
                  cmdReg <= shReg;
                  strobe.cmdValid <= 1'b1;
                  strobe.cmd      <= shReg;
                end else if (byteIdx == 2'd2) begin
                  strobe.dataValid <= 1'b1;
                  strobe.cmd       <= cmdReg;
                  strobe.data      <= shReg;
                end
              end
            end
          end
          ST_ACK: if (sclFall) begin
            if (rwBit && byteIdx == 2'd0) begin
              state <= ST_TX; txSh <= txByte; sdaOe <= ~txByte[7]; bitCnt <= 4'd1;
            end else begin
              state <= ST_RX; sdaOe <= 1'b0;
              if (byteIdx != 2'd3) byteIdx <= byteIdx + 2'd1;
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaOe <= 1'b0; state <= ST_TXACK;
            end else begin
              sdaOe  <= ~txSh[6];
              txSh   <= {txSh[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_TXACK: begin
            if (sclRise) ackd <= ~sdaF;
            else if (sclFall) begin
              if (ackd) begin
                state <= ST_TX; txSh <= txByte; sdaOe <= ~txByte[7]; bitCnt <= 4'd1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: drive on SDA is held while SCL stays high
  p_sda_hold_scl_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && sclPrev) |-> $stable(sdaOe));
  // R2: the ninth clock's high phase sees SDA pulled low
  p_ack_low_ninth_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && sclF) |-> sdaOe);
  // R13: command and data strobes never coincide
  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdValid, strobe.dataValid}));
endmodule

// File: rtl/vcmd_reg_bank.sv
module vcmd_reg_bank
  import vcmd_pkg::*;
#(
  parameter int         NFILT     = 10,
  parameter int         NOISE_W   = 8,
  parameter logic [7:0] NOISE_RST = 8'h1F
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cmdStrobe_t               strobe,
  output logic [7:0]               txByte,
  output logic                     bypass,
  output logic                     eqMode,
  output logic [1:0]               fxLevel,
  output logic [NBANDS*CODE_W-1:0] bandGain,
  output logic [NFILT*4-1:0]       filterGain,
  output logic [NOISE_W-1:0]       noiseLevel
);
  localparam logic [3:0] FILT_MAX = 4'd12;

  logic [CODE_W-1:0] band [NBANDS];
  logic [3:0]        filt [NFILT];
  logic [7:0]        query;
  logic [NBANDS*CODE_W-1:0] preset;
  assign preset = presetWord(strobe.cmd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypass <= 1'b1; eqMode <= 1'b0; fxLevel <= 2'b01;
      noiseLevel <= NOISE_W'(NOISE_RST); query <= 8'h01;
      for (int b = 0; b < NBANDS; b++) band[b] <= BAND_RST[b*CODE_W +: CODE_W];
      for (int f = 0; f < NFILT; f++) filt[f] <= FILT_MAX;
    end else if (strobe.cmdValid) begin
      case (strobe.cmd)
        8'h01: bypass <= 1'b1;
        8'h02: begin bypass <= 1'b0; eqMode <= 1'b0; end
        8'h03: begin bypass <= 1'b0; eqMode <= 1'b1; end
        8'h05, 8'h06, 8'h07, 8'h08, 8'h09:
          for (int b = 0; b < NBANDS; b++) band[b] <= preset[b*CODE_W +: CODE_W];
        default: ;
      endcase
    end else if (strobe.dataValid) begin
      case (strobe.cmd)
        8'h04: if (strobe.data <= 8'd2) fxLevel <= strobe.data[1:0];
        8'h0A: if (strobe.data[4:0] <= 5'(CODE_MAX))
          for (int b = 0; b < NBANDS; b++)
            if (strobe.data[7:5] == 3'(b)) band[b] <= strobe.data[4:0];
        8'h0B: if (strobe.data[3:0] <= FILT_MAX)
          for (int f = 0; f < NFILT; f++)
            if (strobe.data[7:4] == 4'(f)) filt[f] <= strobe.data[3:0];
        8'h0D: noiseLevel <= strobe.data[NOISE_W-1:0];
        8'h0E: query <= strobe.data;
        default: ;
      endcase
    end
  end

  always_comb begin
    txByte = 8'h00;
    if (query == 8'h01) txByte = {4'b0, fxLevel, eqMode, bypass};
    for (int b = 0; b < NBANDS; b++)
      if (query == 8'(b + 2)) txByte = 8'(CODE_MAX) - 8'(band[b]);
  end

  genvar g;
  generate
    for (g = 0; g < NBANDS; g++) begin : gBand
      assign bandGain[g*CODE_W +: CODE_W] = band[g];
      // R7: a stored band code never exceeds the -12 dB code
      p_band_range_r7: assert property (@(posedge clk) disable iff (!rstN)
        bandGain[g*CODE_W +: CODE_W] <= CODE_W'(CODE_MAX));
    end
    for (g = 0; g < NFILT; g++) begin : gFilt
      assign filterGain[g*4 +: 4] = filt[g];
      // R9: filter gains stay within 0..12
      p_filt_range_r9: assert property (@(posedge clk) disable iff (!rstN)
        filterGain[g*4 +: 4] <= FILT_MAX);
    end
  endgenerate

  // R8: the unused level code never appears
  p_level_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    fxLevel != 2'b11);
  // R10: threshold moves only after a 0x0D data strobe
  p_noise_on_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataValid && strobe.cmd == 8'h0D) |=> $stable(noiseLevel));
  // R5: mode bits move only after a command strobe
  p_mode_on_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmdValid |=> ($stable(bypass) && $stable(eqMode)));
endmodule

// File: rtl/vcmd_i2c_slave.sv
module vcmd_i2c_slave
  import vcmd_pkg::*;
#(
  parameter int         NFILT     = 10,
  parameter int         NOISE_W   = 8,
  parameter logic [7:0] NOISE_RST = 8'h1F,
  parameter logic [5:0] ADDR_HI   = 6'b100000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  logic                     addrSel,
  output logic                     sdaOe,
  output logic                     bypass,
  output logic                     eqMode,
  output logic [1:0]               fxLevel,
  output logic [NBANDS*CODE_W-1:0] bandGain,
  output logic [NFILT*4-1:0]       filterGain,
  output logic [NOISE_W-1:0]       noiseLevel
);
  cmdStrobe_t strobe;
  logic [7:0] txByte;

  vcmd_link_ctrl #(.ADDR_HI(ADDR_HI)) i_link (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .txByte(txByte), .sdaOe(sdaOe), .strobe(strobe)
  );

  vcmd_reg_bank #(.NFILT(NFILT), .NOISE_W(NOISE_W), .NOISE_RST(NOISE_RST)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .bypass(bypass), .eqMode(eqMode), .fxLevel(fxLevel), .bandGain(bandGain),
    .filterGain(filterGain), .noiseLevel(noiseLevel)
  );
endmodule

// File: tb/test_vcmd_i2c_slave.sv
`timescale 1ns/1ps
module test_vcmd_i2c_slave;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, addrSel = 1'b0;
  logic sdaOe, bypass, eqMode;
  logic [1:0]  fxLevel;
  logic [19:0] bandGain;
  logic [39:0] filterGain;
  logic [7:0]  noiseLevel;
  wire sdaLine = sdaDrv & ~sdaOe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] rdGot;
  event       rdEv;

  always #4 clk = ~clk;

  vcmd_i2c_slave i_vcmd_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .bypass(bypass), .eqMode(eqMode), .fxLevel(fxLevel),
    .bandGain(bandGain), .filterGain(filterGain), .noiseLevel(noiseLevel)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 10);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclDrv = 1'b1; tick();
    sdaDrv = 1'b0; tick();
    sclDrv = 1'b0; tick();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick();
    sclDrv = 1'b1; tick();
    sdaDrv = 1'b1; tick();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; tick();
      sclDrv = 1'b1; tick();
      sclDrv = 1'b0; tick();
    end
    sdaDrv = 1'b1; tick();
    sclDrv = 1'b1; tick(5);
    ack = ~sdaLine; tick(5);
    sclDrv = 1'b0; tick();
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick();
      sclDrv = 1'b1; tick(5);
      b[i] = sdaLine; tick(5);
      sclDrv = 1'b0;
    end
    tick();
    sdaDrv = ~masterAck; tick();
    sclDrv = 1'b1; tick();
    sclDrv = 1'b0; tick();
    sdaDrv = 1'b1;
  endtask

  // Three-byte (or two-byte) write; every byte's acknowledge is checked (R2).
  task automatic wr(input logic [7:0] c, input logic [7:0] d, input bit withData);
    logic a;
    busStart();
    sendByte({6'b100000, addrSel, 1'b0}, a); check("R2 addr ack", a, 1);
    sendByte(c, a); check("R2 cmd ack", a, 1);
    if (withData) begin sendByte(d, a); check("R2 data ack", a, 1); end
    busStop();
    tick();
  endtask

  // Query then read: the expected byte goes to the scoreboard.
  task automatic rd(input logic [7:0] sel, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] b;
    wr(8'h0E, sel, 1);
    busStart();
    sendByte({6'b100000, addrSel, 1'b1}, a); check("R1 read addr ack", a, 1);
    expQ.push_back(exp); tagQ.push_back(tag);
    recvByte(1'b0, b);
    busStop();
    rdGot = b; ->rdEv;
    tick();
  endtask

  initial begin : monitor
    forever begin
      @(rdEv);
      if (expQ.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tagQ.pop_front(), rdGot, expQ.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin : stim
    logic a;
    tick(3); rstN = 1'b1; tick(3);
    // R4 reset state
    check("R4 bypass", bypass, 1);
    check("R4 eqMode", eqMode, 0);
    check("R4 level", fxLevel, 2'b01);
    check("R4 noise", noiseLevel, 8'h1F);
    check("R4 bands", bandGain, {5'd11, 5'd12, 5'd12, 5'd8});
    check("R4 filters", filterGain, {10{4'hC}});
    check("R2 idle release", sdaOe, 0);
    // R11 status at reset
    rd(8'h01, 8'h05, "R11 status reset");
    // R5 modes
    wr(8'h02, 0, 0);
    check("R5 effect bypass", bypass, 0); check("R5 effect mode", eqMode, 0);
    wr(8'h03, 0, 0);
    check("R5 eq mode", eqMode, 1);
    rd(8'h01, 8'h06, "R11 status eq");
    // R6 presets
    wr(8'h06, 0, 0); check("R6 preset1", bandGain, {5'd11, 5'd13, 5'd13, 5'd9});
    rd(8'h03, 8'd11, "R12 band1 readback");
    wr(8'h09, 0, 0); check("R6 preset4", bandGain, {5'd11, 5'd12, 5'd12, 5'd7});
    wr(8'h07, 0, 0); check("R6 preset2", bandGain, {5'd9, 5'd12, 5'd12, 5'd9});
    wr(8'h05, 0, 0); check("R6 flat", bandGain, {4{5'd12}});
    // R7 tone control incl. limits
    wr(8'h0A, {3'd2, 5'd0}, 1);
    check("R7 band2 +12", bandGain[14:10], 5'd0);
    rd(8'h04, 8'd24, "R12 band2 +12 read");
    wr(8'h0A, {3'd3, 5'd24}, 1);
    rd(8'h05, 8'd0, "R12 band3 -12 read");
    wr(8'h0A, {3'd1, 5'd25}, 1);
    check("R7 code 25 ignored", bandGain, {5'd24, 5'd0, 5'd12, 5'd12});
    wr(8'h0A, {3'd4, 5'd5}, 1);
    check("R7 band 4 ignored", bandGain, {5'd24, 5'd0, 5'd12, 5'd12});
    // R8 level
    wr(8'h04, 8'd2, 1); check("R8 level 60", fxLevel, 2'b10);
    wr(8'h04, 8'd3, 1); check("R8 level 3 ignored", fxLevel, 2'b10);
    rd(8'h01, 8'h0A, "R11 status level");
    // R9 filters
    wr(8'h0B, 8'h95, 1); check("R9 slot9", filterGain[39:36], 4'd5);
    wr(8'h0B, 8'hA1, 1); check("R9 slot10 ignored", filterGain, {4'd5, {9{4'hC}}});
    wr(8'h0B, 8'h2D, 1); check("R9 gain13 ignored", filterGain, {4'd5, {9{4'hC}}});
    wr(8'h0B, 8'h00, 1); check("R9 slot0", filterGain[3:0], 4'd0);
    // R10 noise
    wr(8'h0D, 8'h40, 1); check("R10 noise", noiseLevel, 8'h40);
    // R13 unknown command
    wr(8'h3C, 8'h77, 1);
    check("R13 unknown mode", {bypass, eqMode, fxLevel}, {1'b0, 1'b1, 2'b10});
    check("R13 unknown bands", bandGain, {5'd24, 5'd0, 5'd12, 5'd12});
    check("R13 unknown noise", noiseLevel, 8'h40);
    // R1 wrong address, then pin-selected address
    busStart(); sendByte(8'h84, a); busStop(); tick();
    check("R1 foreign addr nack", a, 0);
    addrSel = 1'b1;
    busStart(); sendByte(8'h80, a); busStop(); tick();
    check("R1 pin moves address", a, 0);
    wr(8'h01, 0, 0); check("R1 R5 bypass via 0x82", bypass, 1);
    rd(8'h01, 8'h0B, "R13 read after NACK");
    tick(20);
    check("R13 idle release", sdaOe, 0);
    check("scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule